// File: doc/BRIEF.md
# Stereo Audio Transmitter Status and Error Register

This block is the status word of a stereo serial audio transmitter whose left and right channels each have their own transmit FIFO. Every clock it registers the level flags of both FIFOs, the busy flag of the shifter, the paused flag and the starved-output flag. It packs them into one 32-bit word that software reads over a simple register bus.

It also keeps a sticky error record. The first fault sets an error flag and stores a 4-bit cause code. Later faults leave that code alone until software clears the flag. Writing one clears the flag, and a separate set alias lets software force it high. When any of the nine low status bits goes from 0 to 1, the matching bit of an interrupt register is set. Software clears that register by writing ones.

Top module: `audtx_stat_reg`

## Requirements
- R1: After reset the status word reads 0x0F000036 and the interrupt register reads 0.
- R2: One clock after being driven, the status word shows the inputs in these places: busy at bit 28, paused at bit 6, and the six FIFO level inputs at bits 5:0. The level inputs are, from bit 5 down to bit 0: right half-full, right space, right done, left half-full, left space, left done.
- R3: Bit 7 (starved output) reads 1 only when the starved input and the DMA-mode input were both high in the previous cycle.
- R4: When the error flag (bit 8) is clear and a fault arrives, the flag sets on the next clock. The code in bits 27:24 then reads 11 for left underflow (event bit 0), 12 for right underflow (bit 1), 13 for a write to a full left FIFO (bit 2) or 14 for a write to a full right FIFO (bit 3). If several faults arrive in the same cycle, the lowest event bit decides the code.
- R5: While the error flag is set and no clear is written, later faults leave the code unchanged.
- R6: A write with the set alias low and data bit 8 high clears the error flag. The code then reads 15. Whenever the flag is clear, the code reads 15.
- R7: A write with the set alias high and data bit 8 high sets the error flag and leaves the code unchanged.
- R8: If a clear and a new fault arrive in the same cycle, the fault wins: the flag stays set and the code takes the new cause.
- R9: A 0-to-1 change of any status bit 8:0 sets the same bit of the interrupt register in the same clock. A bit that stays high does not set it again.
- R10: An interrupt-register write clears each bit written as one. A rise in the same cycle keeps that bit set.
- R11: Bits 31:29 and 23:9 read zero. Status-register writes change nothing except through data bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy_i | input | 1 | Shifter is still transmitting |
| starve_i | input | 1 | No output data although the source is not empty |
| dma_mode_i | input | 1 | Data source is DMA; qualifies starve_i |
| paused_i | input | 1 | Pause request has taken effect |
| fifo_lvl_i | input | 6 | FIFO level flags, right half/space/done then left half/space/done |
| fault_i | input | 4 | Fault strobes: left underflow, right underflow, left full-write, right full-write |
| reg_wr_i | input | 1 | Write strobe for the status word |
| reg_set_i | input | 1 | 1 selects the write-one-to-set alias, 0 selects write-one-to-clear |
| reg_wdata_i | input | 32 | Write data |
| irq_wr_i | input | 1 | Write-one-to-clear strobe for the interrupt register, using reg_wdata_i[8:0] |
| reg_rdata_o | output | 32 | Status word |
| irq_o | output | 9 | Interrupt register, aligned with status bits 8:0 |

## Verification
A wrong sampled flag shows on reg_rdata_o one clock after the input changes. A lost first error shows at the same time, either as a flag that does not rise or as a code other than the expected cause. A code that drifts while the flag is held high shows on the very next cycle, as does a wrong clear-versus-fault decision. A broken edge detector leaves irq_o unset in the same clock as the rise. A level-sensitive detector instead sets irq_o again right after software clears it.

// File: rtl/audtx_stat_pkg.sv
package audtx_stat_pkg;
  localparam int REG_W    = 32;
  localparam int LVL_W    = 6;
  localparam int EVT_W    = 4;
  localparam int CODE_W   = 4;
  localparam int SAMP_W   = LVL_W + 3;  // level flags, paused, starve, busy
  localparam int IRQ_W    = LVL_W + 3;  // low byte plus error flag
  localparam int BUSY_BIT = 28;
  localparam int CODE_LSB = 24;
  localparam int ERR_BIT  = 8;

  localparam logic [CODE_W-1:0] CODE_NONE = 4'hF;
  localparam logic [CODE_W-1:0] CODE_BASE = 4'd11;
  localparam logic [7:0]        LOW_RST   = 8'h36;

  // Lowest event index has priority.
  function automatic logic [CODE_W-1:0] fault_code(input logic [EVT_W-1:0] ev);
    logic [CODE_W-1:0] c;
    c = CODE_NONE;
    for (int i = EVT_W - 1; i >= 0; i--) begin
      if (ev[i]) c = CODE_BASE + CODE_W'(i);
    end
    return c;
  endfunction

  function automatic logic [REG_W-1:0] pack_word(input logic busy,
                                                 input logic [CODE_W-1:0] code,
                                                 input logic err,
                                                 input logic [7:0] low);
    logic [REG_W-1:0] w;
    w = '0;
    w[BUSY_BIT] = busy;
    w[CODE_LSB +: CODE_W] = code;
    w[ERR_BIT] = err;
    w[7:0] = low;
    return w;
  endfunction
endpackage

// File: rtl/audtx_stat_sample.sv
module audtx_stat_sample
  import audtx_stat_pkg::*;
#(
  parameter int W = SAMP_W,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= RST_VAL;
    else        q_o <= d_i;
  end
endmodule

// File: rtl/audtx_err_track.sv
module audtx_err_track
  import audtx_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              clr_i,
  input  logic              set_i,
  output logic              new_err_o,
  output logic              err_nxt_o,
  output logic              err_o,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] code_nxt;

  assign new_err_o = |evt_i;

  always_comb begin
    err_nxt_o = err_o;
    code_nxt  = code_o;
    if (new_err_o && (!err_o || clr_i)) begin
      err_nxt_o = 1'b1;
      code_nxt  = fault_code(evt_i);
    end else if (err_o && clr_i) begin
      err_nxt_o = 1'b0;
      code_nxt  = CODE_NONE;
    end else if (!err_o && set_i) begin
      err_nxt_o = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_o  <= 1'b0;
      code_o <= CODE_NONE;
    end else begin
      err_o  <= err_nxt_o;
      code_o <= code_nxt;
    end
  end
endmodule

// File: rtl/audtx_edge_irq.sv
module audtx_edge_irq #(
  parameter int N = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] nxt_i,
  input  logic [N-1:0] cur_i,
  input  logic         wr_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] irq_o
);
  logic [N-1:0] keep;

  assign rise_o = nxt_i & ~cur_i;
  assign keep   = wr_i ? ~clr_mask_i : '1;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o[g] <= 1'b0;
      else        irq_o[g] <= (irq_o[g] & keep[g]) | rise_o[g];
    end
  end
endmodule

// File: rtl/audtx_stat_reg.sv
module audtx_stat_reg
  import audtx_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              starve_i,
  input  logic              dma_mode_i,
  input  logic              paused_i,
  input  logic [LVL_W-1:0]  fifo_lvl_i,
  input  logic [EVT_W-1:0]  fault_i,
  input  logic              reg_wr_i,
  input  logic              reg_set_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  input  logic              irq_wr_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic [IRQ_W-1:0]  irq_o
);
  localparam logic [SAMP_W-1:0] SAMP_RST = {1'b0, LOW_RST};

  logic [SAMP_W-1:0] samp_d, samp_q;
  logic              clr_req, set_req;
  logic              new_err, err_nxt, err_q;
  logic [CODE_W-1:0] code_q;
  logic [IRQ_W-1:0]  irq_rise;
  logic              unused_wdata;

  assign samp_d  = {busy_i, starve_i & dma_mode_i, paused_i, fifo_lvl_i};
  assign clr_req = reg_wr_i & ~reg_set_i & reg_wdata_i[ERR_BIT];
  assign set_req = reg_wr_i &  reg_set_i & reg_wdata_i[ERR_BIT];
  assign unused_wdata = ^{reg_wdata_i[REG_W-1:IRQ_W]};

  audtx_stat_sample #(.W(SAMP_W), .RST_VAL(SAMP_RST)) u_samp (
    .clk(clk), .rst_n(rst_n), .d_i(samp_d), .q_o(samp_q)
  );

  audtx_err_track u_err (
    .clk(clk), .rst_n(rst_n), .evt_i(fault_i), .clr_i(clr_req), .set_i(set_req),
    .new_err_o(new_err), .err_nxt_o(err_nxt), .err_o(err_q), .code_o(code_q)
  );

  audtx_edge_irq #(.N(IRQ_W)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .nxt_i({err_nxt, samp_d[7:0]}), .cur_i({err_q, samp_q[7:0]}),
    .wr_i(irq_wr_i), .clr_mask_i(reg_wdata_i[IRQ_W-1:0]),
    .rise_o(irq_rise), .irq_o(irq_o)
  );

  assign reg_rdata_o = pack_word(samp_q[SAMP_W-1], code_q, err_q, samp_q[7:0]);
endmodule

// File: rtl/audtx_stat_chk.sv
module audtx_stat_chk
  import audtx_stat_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             dma_mode_i,
  input logic [REG_W-1:0] rd,
  input logic [IRQ_W-1:0] irq,
  input logic             clr_req,
  input logic             new_err
);
  p_nodata_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd[7] |-> $past(dma_mode_i));

  p_first_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd[ERR_BIT] && new_err) |=>
      (rd[ERR_BIT] && rd[CODE_LSB +: CODE_W] >= 4'd11 && rd[CODE_LSB +: CODE_W] <= 4'd14));

  p_code_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd[ERR_BIT] && !clr_req) |=> (rd[ERR_BIT] && $stable(rd[CODE_LSB +: CODE_W])));

  p_idle_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd[ERR_BIT] |-> (rd[CODE_LSB +: CODE_W] == CODE_NONE));

  p_clear_clash_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && new_err) |=> rd[ERR_BIT]);

  p_rise_sets_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd[IRQ_W-1:0] & ~$past(rd[IRQ_W-1:0]) & ~irq) == '0));
endmodule

bind audtx_stat_reg audtx_stat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dma_mode_i(dma_mode_i), .rd(reg_rdata_o),
  .irq(irq_o), .clr_req(clr_req), .new_err(new_err)
);

// File: tb/sim_audtx_stat_reg.sv
module sim_audtx_stat_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busy_i = 0, starve_i = 0, dma_mode_i = 0, paused_i = 0;
  logic [5:0]  fifo_lvl_i = 6'h36;
  logic [3:0]  fault_i = 0;
  logic        reg_wr_i = 0, reg_set_i = 0, irq_wr_i = 0;
  logic [31:0] reg_wdata_i = 0;
  logic [31:0] reg_rdata_o;
  logic [8:0]  irq_o;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // bench model
  logic [7:0] m_low = 8'h36;
  logic       m_busy = 0, m_err = 0;
  logic [3:0] m_code = 4'hF;
  logic [8:0] m_irq = 0;

  always #2.5 clk = ~clk;

  audtx_stat_reg u0 (.*);

  function automatic logic [3:0] exp_cause(input logic [3:0] ev);
    if (ev[0]) return 4'd11;
    if (ev[1]) return 4'd12;
    if (ev[2]) return 4'd13;
    return 4'd14;
  endfunction

  function automatic logic [31:0] exp_word();
    return {3'b000, m_busy, m_code, 15'd0, m_err, m_low};
  endfunction

  task automatic check(input string tag);
    n_vec++;
    if (reg_rdata_o !== exp_word() || irq_o !== m_irq) begin
      n_bad++;
      $display("FAIL %s: rdata=%h irq=%h expected rdata=%h irq=%h",
               tag, reg_rdata_o, irq_o, exp_word(), m_irq);
    end
  endtask

  // Called at a negative edge: drive, advance model, wait one clock, sample.
  task automatic step(input logic b, input logic s, input logic d, input logic p,
                      input logic [5:0] l, input logic [3:0] f,
                      input logic wr, input logic st, input logic [31:0] wd,
                      input logic iw, input string tag);
    logic [8:0] old9, new9;
    logic clr, set, any;
    busy_i = b; starve_i = s; dma_mode_i = d; paused_i = p; fifo_lvl_i = l;
    fault_i = f; reg_wr_i = wr; reg_set_i = st; reg_wdata_i = wd; irq_wr_i = iw;
    old9 = {m_err, m_low};
    clr = wr && !st && wd[8];
    set = wr && st && wd[8];
    any = |f;
    if (any && (clr || !m_err)) begin m_err = 1; m_code = exp_cause(f); end
    else if (m_err && clr)       begin m_err = 0; m_code = 4'hF; end
    else if (!m_err && set)      m_err = 1;
    m_low = {s & d, p, l};
    m_busy = b;
    new9 = {m_err, m_low};
    if (iw) m_irq = m_irq & ~wd[8:0];
    m_irq = m_irq | (new9 & ~old9);
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle(input logic [5:0] l, input string tag);
    step(0, 0, 0, 0, l, 4'h0, 0, 0, 32'h0, 0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset");
    // R2 sampling of busy, paused and level flags
    step(1, 0, 0, 1, 6'h09, 4'h0, 0, 0, 32'h0, 0, "R2 levels");
    step(0, 0, 0, 0, 6'h2A, 4'h0, 0, 0, 32'h0, 0, "R2 levels b");
    // R3 starve qualified by DMA mode
    step(0, 1, 0, 0, 6'h2A, 4'h0, 0, 0, 32'h0, 0, "R3 no dma");
    step(0, 1, 1, 0, 6'h2A, 4'h0, 0, 0, 32'h0, 0, "R3 dma");
    // R4 first error, priority among simultaneous faults
    step(0, 0, 0, 0, 6'h2A, 4'b1100, 0, 0, 32'h0, 0, "R4 first fault");
    // R5 later fault must not change code
    step(0, 0, 0, 0, 6'h2A, 4'b0001, 0, 0, 32'h0, 0, "R5 frozen");
    // R6 clear
    step(0, 0, 0, 0, 6'h2A, 4'h0, 1, 0, 32'h100, 0, "R6 clear");
    step(0, 0, 0, 0, 6'h2A, 4'b1010, 0, 0, 32'h0, 0, "R4 right underflow");
    step(0, 0, 0, 0, 6'h2A, 4'h0, 1, 0, 32'h100, 0, "R6 clear b");
    // R7 set alias
    step(0, 0, 0, 0, 6'h2A, 4'h0, 1, 1, 32'h100, 0, "R7 set");
    // R8 clear and new fault together
    step(0, 0, 0, 0, 6'h2A, 4'b1000, 1, 0, 32'h100, 0, "R8 clash");
    // R10 clear interrupt register
    step(0, 0, 0, 0, 6'h2A, 4'h0, 0, 0, 32'h1FF, 1, "R10 irq clear");
    // R9 level held high does not re-fire
    idle(6'h2A, "R9 held level");
    idle(6'h00, "R9 fall");
    idle(6'h01, "R9 rise");
    // R10 rise wins over simultaneous clear
    step(0, 0, 0, 0, 6'h03, 4'h0, 0, 0, 32'h1FF, 1, "R10 set wins");
    // R11 writes to other bits ignored in both aliases
    step(0, 0, 0, 0, 6'h03, 4'h0, 1, 1, 32'hFFFF_FEFF, 0, "R11 set alias");
    step(0, 0, 0, 0, 6'h03, 4'h0, 1, 0, 32'hFFFF_FEFF, 0, "R11 clear alias");
    // random mix
    void'($urandom(32'd7331));
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      logic [3:0] f;
      r = $urandom;
      f = (r[31:29] == 3'd0) ? r[3:0] : 4'h0;
      step(r[4], r[5], r[6], r[7], r[13:8], f,
           r[16:14] == 3'd0, r[17], {23'd0, r[18], r[26:19]},
           r[28:27] == 2'd0, "R2 R4 R9 random");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule